// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status

This block receives characters on one asynchronous serial line. It oversamples the line on a tick-enable input that runs at sixteen times the bit rate. It checks each frame and places the character in a data register. A status register holds a data-ready flag and three sticky error flags: overrun, parity and framing. Software talks to the block through a small register port. It reads the character, reads the status, and clears flags by writing zeros. A configuration register enables the receiver and selects the character length and the parity mode.

The data-ready flag drives a receive interrupt. Any set error flag drives an error interrupt. While an error flag is set, the receiver ignores new frames, so software has to clear all three error flags before reception continues. For back-to-back traffic, software must clear the data-ready flag before the stop bit of the frame in flight is sampled. If it does not, that frame is dropped and an overrun is recorded. A status bit shows the synchronised pin level, so software can tell a line held low (a break) from a plain framing error.

Top module: `uartRxCore`

## Requirements
- R1: After reset, the configuration register, the four status flags, the data register and both interrupt outputs are 0.
- R2: Configuration register (address 0) bits are: bit0 receive enable, bit1 parity enable, bit2 odd parity (0 = even), bit3 seven-bit characters (0 = eight bits). A character is received LSB first and stored in the data register (address 2). Bit 7 of a seven-bit character reads 0. If the data-ready flag (status bit0) was 0 when the stop bit is sampled, the character is stored and status bit0 becomes 1.
- R3: When parity is enabled, a parity bit follows the data bits. Even parity means the data bits plus the parity bit hold an even number of ones, and odd parity means they hold an odd number. A mismatch sets status bit2.
- R4: A stop bit sampled as 0 sets the framing flag, status bit3.
- R5: If status bit0 is still 1 when a stop bit is sampled, the overrun flag (status bit1) is set and the data register keeps its old value.
- R6: If status bit0 is cleared while a frame is in flight but before its stop bit is sampled, that frame is stored without overrun.
- R7: Writing address 1 clears every flag among status bits 0 to 3 whose written bit is 0. A written 1 leaves the flag unchanged.
- R8: While any of status bits 1 to 3 is 1, no new frame is accepted. Reception resumes once all three are 0.
- R9: Clearing receive enable abandons a frame in progress. No flag or data changes result from it.
- R10: Status bit4 reads the synchronised level of the receive pin, so a held-low line (break) reads 0.
- R11: The receive interrupt equals status bit0. The error interrupt is 1 exactly when any of status bits 1 to 3 is 1.
- R12: A start edge whose level is high again at the start-bit midpoint is discarded as noise.
- R13: Timing advances only on cycles where the tick input is 1. Each bit spans 16 ticks and is sampled at its centre.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxLine | input | 1 | Serial receive line, idle high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 config, 1 status, 2 data) |
| regWdata | input | 4 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| rxIrq | output | 1 | Receive interrupt (data ready) |
| errIrq | output | 1 | Error interrupt (any sticky error) |

## Verification
On every cycle, the assertions check several invariants. The data-ready flag and the parity flag rise only on the cycle after a frame completes. An overrun leaves the data register untouched. The controller stays idle while errors are pending or the receiver is disabled. At most one sampling strobe fires at a time. Only the bench's scenarios can show that the assembled characters are correct across full value sweeps in both character lengths and both parity senses. The same holds for the flag-clearing timing that avoids an overrun, noise rejection, break visibility and sampling at a slower tick rate.

// File: rtl/rx_pkg.sv
package rx_pkg;
  // configuration register bit positions
  localparam int CFG_EN    = 0;
  localparam int CFG_PAR   = 1;
  localparam int CFG_ODD   = 2;
  localparam int CFG_SEVEN = 3;
  localparam int CFG_W     = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } rxState_t;

  typedef struct packed {
    logic frameStart;
    logic dataSample;
    logic paritySample;
    logic frameDone;
  } rxStrobe_t;
endpackage

// File: rtl/rxCtrl.sv
module rxCtrl
  import rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      rxBit,
  input  logic      rxEnable,
  input  logic      parEn,
  input  logic      sevenBits,
  input  logic      anyErr,
  output rxStrobe_t strb
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(MAX_BITS);
  localparam int MID   = OVS / 2 - 1;
  localparam int LAST  = OVS - 1;

  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             go, midHit, endHit, lastBit;

  assign go      = tick16 && rxEnable;
  assign midHit  = (cnt == CNT_W'(MID));
  assign endHit  = (cnt == CNT_W'(LAST));
  assign lastBit = (bitIdx == (sevenBits ? IDX_W'(MAX_BITS - 2) : IDX_W'(MAX_BITS - 1)));

  always_comb begin
    strb.frameStart   = go && (state == ST_IDLE) && !rxBit && !anyErr;
    strb.dataSample   = go && (state == ST_DATA) && endHit;
    strb.paritySample = go && (state == ST_PARITY) && endHit;
    strb.frameDone    = go && (state == ST_STOP) && endHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick16) begin
      case (state)
        ST_IDLE: begin
          if (strb.frameStart) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (midHit) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= rxBit ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (endHit) begin
            cnt <= '0;
            if (lastBit) state <= parEn ? ST_PARITY : ST_STOP;
            else         bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (endHit) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (endHit) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  block_on_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && anyErr) |=> (state == ST_IDLE));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == ST_IDLE));

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/rxData.sv
module rxData
  import rx_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  rxStrobe_t           strb,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [CFG_W-1:0]    regWdata,
  output logic [MAX_BITS-1:0] regRdata,
  output logic                rxBit,
  output logic                rxEnable,
  output logic                parEn,
  output logic                sevenBits,
  output logic                anyErr,
  output logic                fullFlag
);
  logic                syncA, syncB;
  logic [CFG_W-1:0]    cfgReg;
  logic [MAX_BITS-1:0] shiftReg, dataReg, assembled;
  logic                parAcc, parBit, parBad, stopBad;
  logic                ovrFlag, parFlag, frmFlag;
  logic                statWr;

  assign rxBit     = syncB;
  assign rxEnable  = cfgReg[CFG_EN];
  assign parEn     = cfgReg[CFG_PAR];
  assign sevenBits = cfgReg[CFG_SEVEN];
  assign anyErr    = ovrFlag || parFlag || frmFlag;
  assign statWr    = regWe && (regAddr == 2'd1);

  assign assembled = sevenBits ? {1'b0, shiftReg[MAX_BITS-1:1]} : shiftReg;
  assign parBad    = parEn && ((parAcc ^ parBit) != cfgReg[CFG_ODD]);
  assign stopBad   = !rxBit;

  // two-stage synchronizer for the asynchronous pin
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= rxLine;
      syncB <= syncA;
    end
  end

  // assembly shift register and running parity
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
    end else begin
      if (strb.frameStart) parAcc <= 1'b0;
      if (strb.dataSample) begin
        shiftReg <= {rxBit, shiftReg[MAX_BITS-1:1]};
        parAcc   <= parAcc ^ rxBit;
      end
      if (strb.paritySample) parBit <= rxBit;
    end
  end

  // registers and flags: a frame event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      dataReg  <= '0;
      fullFlag <= 1'b0;
      ovrFlag  <= 1'b0;
      parFlag  <= 1'b0;
      frmFlag  <= 1'b0;
    end else begin
      if (regWe && regAddr == 2'd0) cfgReg <= regWdata;
      if (statWr) begin
        if (!regWdata[0]) fullFlag <= 1'b0;
        if (!regWdata[1]) ovrFlag  <= 1'b0;
        if (!regWdata[2]) parFlag  <= 1'b0;
        if (!regWdata[3]) frmFlag  <= 1'b0;
      end
      if (strb.frameDone) begin
        if (fullFlag) begin
          ovrFlag <= 1'b1;
        end else begin
          dataReg  <= assembled;
          fullFlag <= 1'b1;
        end
        if (parBad)  parFlag <= 1'b1;
        if (stopBad) frmFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = MAX_BITS'(cfgReg);
      2'd1:    regRdata = MAX_BITS'({syncB, frmFlag, parFlag, ovrFlag, fullFlag});
      2'd2:    regRdata = dataReg;
      default: regRdata = '0;
    endcase
  end

  // R5
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $stable(dataReg));

  // R2
  full_from_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> $past(strb.frameDone));

  // R3
  par_from_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parFlag) |-> $past(strb.frameDone && parEn));
endmodule

// File: rtl/uartRxCore.sv
module uartRxCore
  import rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick16,
  input  logic                rxLine,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [CFG_W-1:0]    regWdata,
  output logic [MAX_BITS-1:0] regRdata,
  output logic                rxIrq,
  output logic                errIrq
);
  rxStrobe_t strb;
  logic      rxBit, rxEnable, parEn, sevenBits, anyErr, fullFlag;

  rxCtrl #(.OVS(OVS), .MAX_BITS(MAX_BITS)) ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxBit(rxBit),
    .rxEnable(rxEnable), .parEn(parEn), .sevenBits(sevenBits),
    .anyErr(anyErr), .strb(strb)
  );

  rxData #(.MAX_BITS(MAX_BITS)) data (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strb(strb),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rxBit(rxBit), .rxEnable(rxEnable),
    .parEn(parEn), .sevenBits(sevenBits), .anyErr(anyErr),
    .fullFlag(fullFlag)
  );

  assign rxIrq  = fullFlag;
  assign errIrq = anyErr;
endmodule

// File: tb/uartRxCore_test.sv
module uartRxCore_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b1;
  logic       rxLine = 1'b1;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [3:0] regWdata = 4'd0;
  logic [7:0] regRdata;
  logic       rxIrq, errIrq;

  int  tests = 0;
  int  fails = 0;
  int  tickDiv = 1;
  int  ph = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  uartRxCore uut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxLine(rxLine),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  initial forever begin
    @(negedge clk);
    ph = (ph + 1) % tickDiv;
    tick16 = (ph == 0);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nb, input bit pe,
                           input bit po, input bit badPar, input bit badStop);
    int  bitLen = 16 * tickDiv;
    logic p = po ^ badPar;
    rxLine = 1'b0;
    repeat (bitLen) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxLine = d[i];
      p = p ^ d[i];
      repeat (bitLen) @(negedge clk);
    end
    if (pe) begin
      rxLine = p;
      repeat (bitLen) @(negedge clk);
    end
    rxLine = !badStop;
    repeat (bitLen) @(negedge clk);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic goodFrame(input string tag, input logic [7:0] v, input int nb,
                           input bit pe, input bit po);
    logic [7:0] s, d;
    logic [7:0] mask = (nb == 7) ? 8'h7F : 8'hFF;
    sendFrame(v, nb, pe, po, 0, 0);
    rd(2'd1, s);  chk({tag, " status"}, s, 8'h11);
    rd(2'd2, d);  chk({tag, " data"}, d, v & mask);
    chk("R11 rxIrq set", rxIrq, 1);
    chk("R11 errIrq clear", errIrq, 0);
    regWr(2'd1, 4'h0);
    chk("R7 full cleared", rxIrq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, s); chk("R1 config", s, 8'h00);
    rd(2'd1, s); chk("R1 status flags", s & 8'h0F, 8'h00);
    rd(2'd2, s); chk("R1 data", s, 8'h00);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 errIrq", errIrq, 0);

    // R2 R3: eight bits, even parity, every value
    regWr(2'd0, 4'b0011);
    for (int v = 0; v < 256; v++) goodFrame("R2 R3 8E", 8'(v), 8, 1, 0);

    // R2 R3: seven bits, odd parity, every value
    regWr(2'd0, 4'b1111);
    for (int v = 0; v < 128; v++) goodFrame("R2 R3 7O", 8'(v), 7, 1, 1);

    // R2: eight bits, no parity, spread of values
    regWr(2'd0, 4'b0001);
    for (int k = 0; k < 32; k++) goodFrame("R2 8N", 8'((k * 37 + 5) % 256), 8, 0, 0);

    // R3 parity error
    regWr(2'd0, 4'b0011);
    sendFrame(8'hA5, 8, 1, 0, 1, 0);
    rd(2'd1, s); chk("R3 parity flag", s, 8'h15);
    rd(2'd2, d); chk("R3 data kept", d, 8'hA5);
    chk("R11 errIrq on parity", errIrq, 1);

    // R7 writing ones leaves flags; R8 blocked while error pending
    regWr(2'd1, 4'hE);
    rd(2'd1, s); chk("R7 only full cleared", s, 8'h14);
    sendFrame(8'h3C, 8, 1, 0, 0, 0);
    rd(2'd1, s); chk("R8 blocked status", s, 8'h14);
    rd(2'd2, d); chk("R8 blocked data", d, 8'hA5);
    regWr(2'd1, 4'h0);
    chk("R11 errIrq cleared", errIrq, 0);
    goodFrame("R8 resumed", 8'h3C, 8, 1, 0);

    // R4 framing, R10 break visibility
    sendFrame(8'h5A, 8, 1, 0, 0, 1);
    rd(2'd1, s); chk("R4 framing flag", s, 8'h19);
    rd(2'd2, d); chk("R4 data", d, 8'h5A);
    rxLine = 1'b0;
    repeat (20) @(negedge clk);
    rd(2'd1, s); chk("R10 break pin low", s, 8'h09);
    rxLine = 1'b1;
    repeat (10) @(negedge clk);
    rd(2'd1, s); chk("R10 pin high", s, 8'h19);
    regWr(2'd1, 4'h0);

    // R5 overrun
    sendFrame(8'h11, 8, 1, 0, 0, 0);
    sendFrame(8'h22, 8, 1, 0, 0, 0);
    rd(2'd1, s); chk("R5 overrun flag", s, 8'h13);
    rd(2'd2, d); chk("R5 old data kept", d, 8'h11);
    chk("R11 errIrq on overrun", errIrq, 1);
    regWr(2'd1, 4'h0);

    // R6 clear during the next frame avoids overrun
    sendFrame(8'h44, 8, 1, 0, 0, 0);
    fork
      sendFrame(8'h55, 8, 1, 0, 0, 0);
      begin
        repeat (100) @(negedge clk);
        rd(2'd2, d); chk("R6 first data", d, 8'h44);
        regWr(2'd1, 4'h0);
      end
    join
    rd(2'd1, s); chk("R6 no overrun", s, 8'h11);
    rd(2'd2, d); chk("R6 second data", d, 8'h55);
    regWr(2'd1, 4'h0);

    // R9 abort by disabling mid-frame
    fork
      sendFrame(8'h66, 8, 1, 0, 0, 0);
      begin
        repeat (60) @(negedge clk);
        regWr(2'd0, 4'b0010);
      end
    join
    rd(2'd1, s); chk("R9 abort no flags", s, 8'h10);
    rd(2'd2, d); chk("R9 abort data unchanged", d, 8'h55);
    regWr(2'd0, 4'b0011);
    goodFrame("R9 after re-enable", 8'h77, 8, 1, 0);

    // R12 glitch rejected
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (300) @(negedge clk);
    rd(2'd1, s); chk("R12 glitch ignored", s, 8'h10);
    goodFrame("R12 after glitch", 8'h81, 8, 1, 0);

    // R13 slower tick
    tickDiv = 2;
    goodFrame("R13 tick/2", 8'h9C, 8, 1, 0);
    tickDiv = 3;
    goodFrame("R13 tick/3", 8'h63, 8, 1, 0);
    tickDiv = 1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule